// File: doc/BRIEF.md
# Binary-Field Multiplicative Inverter

This block computes the multiplicative inverse of a nonzero element of the binary field GF(2^M). It uses the Itoh-Tsujii method: the inverse equals a^(2^M-2), and this power is reached by walking an addition chain for M-1. Every chain value k is held as the partial power a^(2^k-1). The walk alternates between two operations. The first is a run of repeated squarings from a power block. The power block is a cascade of US squaring circuits with a select mux, so one cycle applies up to US squarings. The second is one field multiplication on a bit-serial multiplier. A single squaring of a^(2^(M-1)-1) then gives the result.

The addition chain is a constant table that is computed when the block is elaborated. The partial powers are kept in a small register file indexed by chain position, and each chain step reads its second factor from that file. The caller raises `start` for one cycle with the operand. Some cycles later `done` pulses with the inverse on `result`. A zero operand has no inverse. For a zero operand the block returns zero and raises `zero_err`.

The control is a single state machine with these states. IDLE waits for start. SETUP loads the squaring operand and count for the next chain step. SQUARE runs the power block. MUL_ISSUE launches the multiplier. MUL_WAIT waits for the product and stores it. FINAL applies the last squaring. REPORT pulses done.

The transitions are:
- IDLE goes to REPORT on a zero start and to SETUP on a nonzero start.
- SETUP goes to FINAL once every chain step is done, and to SQUARE otherwise.
- SQUARE stays in SQUARE while more than US squarings remain, and goes to MUL_ISSUE otherwise.
- MUL_ISSUE always goes to MUL_WAIT.
- MUL_WAIT goes back to SETUP when the product is ready.
- FINAL goes to REPORT, and REPORT returns to IDLE.

Top module: `gf_inverter`

## Requirements
- R1: For a nonzero operand a accepted in IDLE, the `result` shown with `done` is a^(2^M-2), so that a·result = 1 modulo the field polynomial x^M + POLY. With the defaults (M=233, POLY = x^74 + 1), the inverse of 1 is 1 and the inverse of x (operand value 2) has bits 232 and 73 set.
- R2: A zero operand accepted in IDLE gives result 0 and zero_err = 1, with done high in the cycle right after the start cycle.
- R3: The addition chain for M-1 is built by the binary method. It starts at 1 and scans the bits of M-1 below its top set bit, from high to low. Each bit doubles the value (one step, squaring count equal to the previous value, second factor the previous entry). A set bit then adds one more step (squaring count 1, second factor a). For the defaults the chain is 1,2,3,6,7,14,28,29,58,116,232.
- R4: The power block applies min(remaining, US) squarings per SQUARE cycle. The latency from the start cycle to the done cycle is therefore 3 + Σ over chain steps of (M + 3 + ceil(q/US)), where q is the step's squaring count. With the defaults this is 2426 cycles.
- R5: done is high for exactly one cycle per accepted start. result and zero_err keep their values while the block is idle.
- R6: The operand is captured in the start cycle. While a computation runs, start pulses and changes on `operand` have no effect on the result or on the latency.
- R7: After reset, done, result and zero_err are all 0.
- R8: A nonzero operand accepted after a zero one clears zero_err, so the next done shows zero_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an inversion; sampled only in IDLE |
| operand | input | M | Field element to invert, captured with start |
| result | output | M | Inverse of the captured operand, valid with done |
| done | output | 1 | One-cycle pulse when result is ready |
| zero_err | output | 1 | High when the last accepted operand was zero |

## Verification
A new start can coincide with a computation that is still running. The bench provokes this by pulsing start with the complemented operand, while also changing the operand lines, about twenty cycles into an inversion. It then judges both the result (a·result = 1 for the original operand) and the latency against the chain formula. A second coincidence is done in the same cycle as a following request. The scoreboard driver issues each new start in the cycle after done is observed, and the monitor checks that every done pairs with exactly one queued item.

// File: rtl/gf_inv_pkg.sv
package gf_inv_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_SQUARE,
        S_MUL_ISSUE,
        S_MUL_WAIT,
        S_FINAL,
        S_REPORT
    } inv_state_e;

    // Highest set bit position of a positive integer.
    function automatic int top_bit(input int t);
        int r;
        r = 0;
        for (int b = 0; b < 31; b++) begin
            if (t[b]) r = b;
        end
        return r;
    endfunction

    // Number of entries of the binary-method chain ending at t.
    function automatic int chain_len(input int t);
        int pos;
        int hb;
        pos = 0;
        hb  = top_bit(t);
        for (int b = 30; b >= 0; b--) begin
            if (b < hb) begin
                pos++;
                if (t[b]) pos++;
            end
        end
        return pos + 1;
    endfunction

    // Value of chain entry idx.
    function automatic int chain_val(input int t, input int idx);
        int v;
        int pos;
        int hb;
        int r;
        v   = 1;
        pos = 0;
        r   = 1;
        hb  = top_bit(t);
        for (int b = 30; b >= 0; b--) begin
            if (b < hb) begin
                v = 2 * v;
                pos++;
                if (pos == idx) r = v;
                if (t[b]) begin
                    v = v + 1;
                    pos++;
                    if (pos == idx) r = v;
                end
            end
        end
        return r;
    endfunction

    // Index of the entry whose partial power multiplies step idx.
    function automatic int chain_src(input int t, input int idx);
        int pos;
        int hb;
        int r;
        pos = 0;
        r   = 0;
        hb  = top_bit(t);
        for (int b = 30; b >= 0; b--) begin
            if (b < hb) begin
                pos++;
                if (pos == idx) r = pos - 1;
                if (t[b]) begin
                    pos++;
                    if (pos == idx) r = 0;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/gf_square.sv
module gf_square #(
    parameter int          M    = 233,
    parameter logic [M-1:0] POLY = M'(1) | (M'(1) << 74)
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] y
);
    localparam int W2 = 2 * M;

    logic [W2-1:0] wide;

    always_comb begin
        wide = '0;
        for (int i = 0; i < M; i++) begin
            wide[2*i] = a[i];
        end
        // Fold each bit at or above M back with the reduction terms.
        for (int i = W2 - 2; i >= M; i--) begin
            if (wide[i]) begin
                wide[i-M +: M] = wide[i-M +: M] ^ POLY;
            end
        end
        y = wide[M-1:0];
    end

endmodule

// File: rtl/gf_pow_block.sv
module gf_pow_block #(
    parameter int          M    = 233,
    parameter logic [M-1:0] POLY = M'(1) | (M'(1) << 74),
    parameter int          US   = 4,
    localparam int         SW   = $clog2(US + 1)
) (
    input  logic [M-1:0]  din,
    input  logic [SW-1:0] sel,
    output logic [M-1:0]  dout
);
    logic [M-1:0] stg [US+1];

    assign stg[0] = din;

    for (genvar g = 0; g < US; g++) begin : g_stage
        gf_square #(.M(M), .POLY(POLY)) u_sq (
            .a (stg[g]),
            .y (stg[g+1])
        );
    end

    assign dout = stg[sel];

endmodule

// File: rtl/gf_mul_serial.sv
module gf_mul_serial #(
    parameter int          M    = 233,
    parameter logic [M-1:0] POLY = M'(1) | (M'(1) << 74),
    localparam int         CW   = $clog2(M + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [M-1:0] x,
    input  logic [M-1:0] y,
    output logic [M-1:0] prod,
    output logic         fin
);
    logic [M-1:0]  xr;
    logic [M-1:0]  yr;
    logic [M-1:0]  acc;
    logic [CW-1:0] cnt;
    logic [M-1:0]  acc_sh;

    // acc * x reduced, plus x when the current multiplier bit is set
    always_comb begin
        acc_sh = {acc[M-2:0], 1'b0};
        if (acc[M-1]) acc_sh = acc_sh ^ POLY;
        if (yr[M-1])  acc_sh = acc_sh ^ xr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xr  <= '0;
            yr  <= '0;
            acc <= '0;
            cnt <= '0;
            fin <= 1'b0;
        end else if (go) begin
            xr  <= x;
            yr  <= y;
            acc <= '0;
            cnt <= CW'(M);
            fin <= 1'b0;
        end else if (cnt != '0) begin
            acc <= acc_sh;
            yr  <= {yr[M-2:0], 1'b0};
            cnt <= cnt - CW'(1);
            fin <= (cnt == CW'(1));
        end else begin
            fin <= 1'b0;
        end
    end

    assign prod = acc;

endmodule

// File: rtl/gf_inverter.sv
module gf_inverter
    import gf_inv_pkg::*;
#(
    parameter int          M    = 233,
    parameter logic [M-1:0] POLY = M'(1) | (M'(1) << 74),
    parameter int          US   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] operand,
    output logic [M-1:0] result,
    output logic         done,
    output logic         zero_err
);
    localparam int TGT  = M - 1;
    localparam int NLEN = chain_len(TGT);
    localparam int IW   = $clog2(NLEN + 1);
    localparam int QW   = $clog2(M);
    localparam int SW   = $clog2(US + 1);

    inv_state_e st, st_nx;

    // Constant chain table: squaring count and second-factor index per step.
    logic [QW-1:0] tab_q   [NLEN];
    logic [IW-1:0] tab_src [NLEN];

    for (genvar g = 0; g < NLEN; g++) begin : g_tab
        assign tab_q[g]   = QW'(chain_val(TGT, chain_src(TGT, g)));
        assign tab_src[g] = IW'(chain_src(TGT, g));
    end

    // Partial powers a^(2^c[k]-1), indexed by chain position.
    logic [M-1:0]  rf [NLEN];
    logic [IW-1:0] step;
    logic [QW-1:0] rem;
    logic [M-1:0]  sq_val;

    logic [M-1:0]  pb_in;
    logic [M-1:0]  pb_out;
    logic [SW-1:0] pb_sel;
    logic          mul_go;
    logic          mul_fin;
    logic [M-1:0]  mul_prod;
    logic [M-1:0]  mul_y;
    logic          last_step;
    logic          sq_tail;

    assign last_step = (step == IW'(NLEN));
    assign sq_tail   = (rem <= QW'(US));

    always_comb begin
        if (st == S_FINAL) begin
            pb_in  = rf[NLEN-1];
            pb_sel = SW'(1);
        end else begin
            pb_in  = sq_val;
            pb_sel = sq_tail ? SW'(rem) : SW'(US);
        end
    end

    gf_pow_block #(.M(M), .POLY(POLY), .US(US)) u_pow (
        .din  (pb_in),
        .sel  (pb_sel),
        .dout (pb_out)
    );

    assign mul_go = (st == S_MUL_ISSUE);
    assign mul_y  = rf[tab_src[step]];

    gf_mul_serial #(.M(M), .POLY(POLY)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mul_go),
        .x     (sq_val),
        .y     (mul_y),
        .prod  (mul_prod),
        .fin   (mul_fin)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:      if (start) st_nx = (operand == '0) ? S_REPORT : S_SETUP;
            S_SETUP:     st_nx = last_step ? S_FINAL : S_SQUARE;
            S_SQUARE:    if (sq_tail) st_nx = S_MUL_ISSUE;
            S_MUL_ISSUE: st_nx = S_MUL_WAIT;
            S_MUL_WAIT:  if (mul_fin) st_nx = S_SETUP;
            S_FINAL:     st_nx = S_REPORT;
            S_REPORT:    st_nx = S_IDLE;
            default:     st_nx = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step     <= '0;
            rem      <= '0;
            sq_val   <= '0;
            result   <= '0;
            zero_err <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        rf[0]    <= operand;
                        step     <= IW'(1);
                        zero_err <= (operand == '0);
                        if (operand == '0) result <= '0;
                    end
                end
                S_SETUP: begin
                    if (!last_step) begin
                        sq_val <= rf[step - IW'(1)];
                        rem    <= tab_q[step];
                    end
                end
                S_SQUARE: begin
                    sq_val <= pb_out;
                    rem    <= rem - QW'(pb_sel);
                end
                S_MUL_WAIT: begin
                    if (mul_fin) begin
                        rf[step] <= mul_prod;
                        step     <= step + IW'(1);
                    end
                end
                S_FINAL: result <= pb_out;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done = (st == S_REPORT);
    end

endmodule

// File: rtl/gf_inverter_chk.sv
module gf_inverter_chk
    import gf_inv_pkg::*;
#(
    parameter int M    = 233,
    parameter int US   = 4,
    parameter int QW   = 8,
    parameter int IW   = 4,
    parameter int NLEN = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [M-1:0]  operand,
    input logic [M-1:0]  result,
    input logic          done,
    input logic          zero_err,
    input inv_state_e    st,
    input logic [QW-1:0] rem,
    input logic [IW-1:0] step
);
    // R2
    a_r2_zero_report: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && start && operand == '0) |=> (done && zero_err && result == '0));

    // R5
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !start) |=> ($stable(result) && $stable(zero_err)));

    // R4
    a_r4_full_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SQUARE && rem > QW'(US)) |=> (st == S_SQUARE && rem == $past(rem) - QW'(US)));

    // R4
    a_r4_tail_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SQUARE && rem <= QW'(US)) |=> (st == S_MUL_ISSUE));

    // R1
    a_r1_nonzero_out: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !zero_err) |-> (result != '0));

    // R3
    a_r3_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |-> (step >= IW'(1) && step <= IW'(NLEN)));

    // R6
    a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SQUARE && start) |=> (st == S_SQUARE || st == S_MUL_ISSUE));

endmodule

bind gf_inverter gf_inverter_chk #(
    .M(M), .US(US), .QW(QW), .IW(IW), .NLEN(NLEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .operand  (operand),
    .result   (result),
    .done     (done),
    .zero_err (zero_err),
    .st       (st),
    .rem      (rem),
    .step     (step)
);

// File: tb/tb_gf_inverter.sv
module tb_gf_inverter;
    localparam int          M    = 233;
    localparam int          US   = 4;
    localparam logic [M-1:0] POLY = M'(1) | (M'(1) << 74);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] operand = '0;
    logic [M-1:0] result;
    logic         done;
    logic         zero_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [M-1:0] a;
        int           t0;
        bit           has_exact;
        logic [M-1:0] exact;
    } item_t;

    item_t        sb[$];
    logic [M-1:0] last_res;
    logic         last_err;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gf_inverter #(.M(M), .POLY(POLY), .US(US)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .operand  (operand),
        .result   (result),
        .done     (done),
        .zero_err (zero_err)
    );

    // Shift-and-add reference product, LSB first.
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r;
        logic [M-1:0] aa;
        logic         hi;
        r  = '0;
        aa = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) r = r ^ aa;
            hi = aa[M-1];
            aa = {aa[M-2:0], 1'b0};
            if (hi) aa = aa ^ POLY;
        end
        return r;
    endfunction

    // Latency from the chain rule of R3 and R4.
    function automatic int exp_lat();
        int t;
        int v;
        int hb;
        int tot;
        t   = M - 1;
        hb  = 0;
        for (int b = 0; b < 31; b++) if (t[b]) hb = b;
        v   = 1;
        tot = 3;
        for (int b = 30; b >= 0; b--) begin
            if (b < hb) begin
                tot = tot + M + 3 + (v + US - 1) / US;
                v   = 2 * v;
                if (t[b]) begin
                    tot = tot + M + 3 + (1 + US - 1) / US;
                    v   = v + 1;
                end
            end
        end
        return tot;
    endfunction

    function automatic logic [M-1:0] rnd_elem();
        logic [M-1:0] r;
        r = '0;
        for (int w = 0; w < (M + 31) / 32; w++) r = (r << 32) | M'($urandom);
        if (r == '0) r = M'(5);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [M-1:0] act,
                         input logic [M-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Driver: push expected item, pulse start, optionally disturb mid-run (R6).
    task automatic issue(input logic [M-1:0] a, input bit poke, input bit has_exact,
                         input logic [M-1:0] exact);
        item_t it;
        wait (sb.size() == 0);
        @(negedge clk);
        operand      = a;
        start        = 1'b1;
        it.a         = a;
        it.t0        = cyc;
        it.has_exact = has_exact;
        it.exact     = exact;
        sb.push_back(it);
        @(negedge clk);
        start   = 1'b0;
        operand = rnd_elem();
        if (poke) begin
            repeat (20) @(negedge clk);
            operand = ~a;
            start   = 1'b1;
            @(negedge clk);
            start   = 1'b0;
            operand = rnd_elem();
        end
    endtask

    // Monitor: pop on each done and compare.
    initial begin
        logic prev_done;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (done && prev_done) check(1'b0, "R5 done longer than one cycle", M'(1), M'(0));
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5 done without request", M'(1), M'(0));
                end else begin
                    item_t it;
                    int    lat;
                    it  = sb.pop_front();
                    lat = cyc - it.t0;
                    last_res = result;
                    last_err = zero_err;
                    if (it.a == '0) begin
                        check(result == '0, "R2 zero result", result, '0);
                        check(zero_err == 1'b1, "R2 zero flag", M'(zero_err), M'(1));
                        check(lat == 1, "R2 zero latency", M'(lat), M'(1));
                    end else begin
                        check(ref_mul(it.a, result) == M'(1), "R1 a*result",
                              ref_mul(it.a, result), M'(1));
                        check(zero_err == 1'b0, "R8 flag clear on nonzero", M'(zero_err), M'(0));
                        check(lat == exp_lat(), "R3/R4 latency (R6 when disturbed)",
                              M'(lat), M'(exp_lat()));
                        if (it.has_exact)
                            check(result == it.exact, "R1 exact inverse", result, it.exact);
                    end
                end
            end
            prev_done = done;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R7 reset state
        check(done == 1'b0, "R7 reset done", M'(done), M'(0));
        check(result == '0, "R7 reset result", result, '0);
        check(zero_err == 1'b0, "R7 reset flag", M'(zero_err), M'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        issue(M'(1), 1'b0, 1'b1, M'(1));
        issue(M'(2), 1'b0, 1'b1, (M'(1) << 232) | (M'(1) << 73));
        issue('0, 1'b0, 1'b0, '0);
        issue(rnd_elem(), 1'b0, 1'b0, '0);      // R8 after zero
        issue('1, 1'b0, 1'b0, '0);
        issue(rnd_elem(), 1'b1, 1'b0, '0);      // R6 disturbed
        issue('0, 1'b0, 1'b0, '0);
        issue(M'(1) << (M - 1), 1'b1, 1'b0, '0);
        for (int k = 0; k < 8; k++) issue(rnd_elem(), k[0], 1'b0, '0);
        wait (sb.size() == 0);

        // R5: outputs hold while idle
        repeat (6) @(negedge clk);
        check(result == last_res, "R5 result held", result, last_res);
        check(zero_err == last_err, "R5 flag held", M'(zero_err), M'(last_err));
        check(done == 1'b0, "R5 done low when idle", M'(done), M'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule